// File: doc/BRIEF.md
# Seven-Slot Pixel Serializer

This block turns a stream of parallel pixels into the bit streams of a low-voltage differential display link. Each pixel carries 8-bit red, green and blue values plus horizontal sync, vertical sync and a data-enable flag. The block splits every pixel period into seven slots. For each of up to four data lanes it builds a seven-bit slot word and sends one bit per cycle of a fast clock that runs at seven times the pixel rate. A clock lane with a fixed seven-slot pattern is sent alongside the data lanes.

The whole block runs on the fast clock. The pixel source holds each pixel for seven fast-clock cycles, with the period aligned to the first rising edge after reset is released. A 2-bit select chooses one of three colour layouts: one with 18-bit colour on three lanes, or one of two 24-bit layouts on four lanes. A mirror input reverses the order in which the slots of every data lane are sent. The pixel, the select and the mirror input are all sampled once per period, at the edge that starts slot 0.

Top module: `pix7_serializer`

## Requirements
- R1: Each pixel period takes seven consecutive fast-clock cycles, with slots sent in the order 0 through 6. The inputs are sampled at the rising edge that starts slot 0. The first such edge is the first rising edge at which reset is low. The slot value appears on the outputs during the cycle after the edge that launches it.
- R2: Over slots 0 to 6, `lane_clk_o` follows the pattern 1,1,0,0,0,1,1.
- R3: With `map_sel`=0 (18-bit layout), the slots of each lane are as follows. Lane 0 sends G0,R5,R4,R3,R2,R1,R0. Lane 1 sends B1,B0,G5,G4,G3,G2,G1. Lane 2 sends DE,VS,HS,B5,B4,B3,B2. Lane 3 stays low in every slot. Colour bits 7:6 have no effect in this layout.
- R4: With `map_sel`=1, the slots of each lane are as follows. Lane 0 sends G2,R7..R2. Lane 1 sends B3,B2,G7..G3. Lane 2 sends DE,VS,HS,B7..B4. Lane 3 sends 0,B1,B0,G1,G0,R1,R0.
- R5: With `map_sel`=2, lanes 0 to 2 use the R3 layout on colour bits 5:0, and lane 3 sends 0,B7,B6,G7,G6,R7,R6.
- R6: `map_sel`=3 is reserved and gives exactly the output of `map_sel`=0.
- R7: Control slots are fixed. Slot 2 of lane 2 carries horizontal sync, slot 1 carries vertical sync and slot 0 carries data enable. Slot 0 of lane 3 is always 0.
- R8: When `mirror` is 1 at the sampling edge, every data lane sends its slot word in the order 6 down to 0. The clock lane is not affected.
- R9: Changes to the pixel, `map_sel` or `mirror` after the sampling edge do not affect the period already being sent.
- R10: A synchronous, active-high `rst` drives all lanes and the clock lane low and restarts the period. The first edge with `rst` low then starts a new slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, seven cycles per pixel |
| rst | input | 1 | Synchronous active-high reset |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| map_sel | input | 2 | Layout select: 0 18-bit, 1 and 2 24-bit, 3 reserved |
| mirror | input | 1 | Reverse the slot order on the data lanes |
| lane_data_o | output | 4 | Serial data lanes, bit n is lane n |
| lane_clk_o | output | 1 | Clock lane pattern |

## Verification
The bench sends asymmetric pixel values in every layout, so a swapped lane, a shifted slot or a colour bit taken from the wrong end shows up as a bit mismatch in a named slot. Pixels that differ only in bits 7:6 in the 18-bit and reserved layouts catch a design that leaks those bits or treats the reserved code as a 24-bit layout. Mirrored periods catch a design that reverses the clock lane too, or reverses only some lanes. The bench also disturbs the inputs in the middle of a period and asserts reset in the middle of a period. A design that does not hold the sampled word would send a mix of two pixels, and a design whose counter does not restart would send slots out of phase.

// File: rtl/pix7_pkg.sv
`timescale 1ns/1ps
package pix7_pkg;
    localparam int SLOTS   = 7;
    localparam int LANES   = 4;
    localparam int COLOR_W = 8;
    localparam int SLOT_W  = $clog2(SLOTS);

    typedef enum logic [1:0] {
        MAP_18   = 2'd0,
        MAP_24A  = 2'd1,
        MAP_24B  = 2'd2,
        MAP_RSVD = 2'd3
    } map_e;

    // bit s of a slot word is the value sent in slot s
    typedef logic [SLOTS-1:0] slot_word_t;

    typedef struct packed {
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
        logic               hs;
        logic               vs;
        logic               de;
    } pixel_t;

    // clock lane: high in slots 0,1,5,6
    localparam slot_word_t CLK_PATTERN = 7'b1100011;
endpackage

// File: rtl/pix7_lane_mapper.sv
`timescale 1ns/1ps
module pix7_lane_mapper
    import pix7_pkg::*;
(
    input  pixel_t                      pix_i,
    input  map_e                        sel_i,
    output slot_word_t [LANES-1:0]      words_o
);
    function automatic slot_word_t w7(input logic s0, input logic s1, input logic s2,
                                      input logic s3, input logic s4, input logic s5,
                                      input logic s6);
        return {s6, s5, s4, s3, s2, s1, s0};
    endfunction

    slot_word_t low0, low1, low2;
    slot_word_t high0, high1, high2;
    slot_word_t ext_a, ext_b;

    always_comb begin
        // six-bit layout on colour bits 5:0
        low0  = w7(pix_i.g[0], pix_i.r[5], pix_i.r[4], pix_i.r[3], pix_i.r[2], pix_i.r[1], pix_i.r[0]);
        low1  = w7(pix_i.b[1], pix_i.b[0], pix_i.g[5], pix_i.g[4], pix_i.g[3], pix_i.g[2], pix_i.g[1]);
        low2  = w7(pix_i.de, pix_i.vs, pix_i.hs, pix_i.b[5], pix_i.b[4], pix_i.b[3], pix_i.b[2]);
        // eight-bit layout, upper bits on lanes 0..2
        high0 = w7(pix_i.g[2], pix_i.r[7], pix_i.r[6], pix_i.r[5], pix_i.r[4], pix_i.r[3], pix_i.r[2]);
        high1 = w7(pix_i.b[3], pix_i.b[2], pix_i.g[7], pix_i.g[6], pix_i.g[5], pix_i.g[4], pix_i.g[3]);
        high2 = w7(pix_i.de, pix_i.vs, pix_i.hs, pix_i.b[7], pix_i.b[6], pix_i.b[5], pix_i.b[4]);
        // fourth-lane words, slot 0 is the spare control bit tied low
        ext_a = w7(1'b0, pix_i.b[1], pix_i.b[0], pix_i.g[1], pix_i.g[0], pix_i.r[1], pix_i.r[0]);
        ext_b = w7(1'b0, pix_i.b[7], pix_i.b[6], pix_i.g[7], pix_i.g[6], pix_i.r[7], pix_i.r[6]);

        unique case (sel_i)
            MAP_24A: words_o = {ext_a, high2, high1, high0};
            MAP_24B: words_o = {ext_b, low2, low1, low0};
            default: words_o = {slot_word_t'('0), low2, low1, low0};
        endcase
    end
endmodule

// File: rtl/pix7_slot_seq.sv
`timescale 1ns/1ps
module pix7_slot_seq
    import pix7_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot_o,
    output logic              load_o,
    output logic              clk_lane_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] cnt;
        logic              clk_lane;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt      = '0;
            st_d.clk_lane = 1'b0;
        end else begin
            st_d.clk_lane = CLK_PATTERN[st_q.cnt];
            st_d.cnt      = (st_q.cnt == LAST_SLOT) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign slot_o     = st_q.cnt;
    assign load_o     = (st_q.cnt == '0);
    assign clk_lane_o = st_q.clk_lane;

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST_SLOT);                                              // R1
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == LAST_SLOT) |=> (st_q.cnt == '0));                       // R1
    AST_CLK_FALL_SLOT: assert property (@(posedge clk) disable iff (rst)
        ($fell(st_q.clk_lane) && !$past(rst)) |-> (st_q.cnt == SLOT_W'(3))); // R2
endmodule

// File: rtl/pix7_lane_shift.sv
`timescale 1ns/1ps
module pix7_lane_shift
    import pix7_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic       mirror_i,
    input  slot_word_t word_i,
    output logic       bit_o
);
    typedef struct packed {
        slot_word_t sh;
        logic       bit_out;
    } lane_st_t;

    lane_st_t   st_d, st_q;
    slot_word_t eff;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            eff[i] = mirror_i ? word_i[SLOTS-1-i] : word_i[i];
        end
        st_d = st_q;
        if (rst) begin
            st_d.sh      = '0;
            st_d.bit_out = 1'b0;
        end else if (load_i) begin
            st_d.bit_out = eff[0];
            st_d.sh      = eff >> 1;
        end else begin
            st_d.bit_out = st_q.sh[0];
            st_d.sh      = st_q.sh >> 1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bit_o = st_q.bit_out;

    AST_SHREG_DRAINED: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (st_q.sh == '0));                                         // R1
endmodule

// File: rtl/pix7_serializer.sv
`timescale 1ns/1ps
module pix7_serializer
    import pix7_pkg::*;
(
    input  logic         clk_fast,
    input  logic         rst,
    input  logic [7:0]   pix_r,
    input  logic [7:0]   pix_g,
    input  logic [7:0]   pix_b,
    input  logic         pix_hs,
    input  logic         pix_vs,
    input  logic         pix_de,
    input  logic [1:0]   map_sel,
    input  logic         mirror,
    output logic [3:0]   lane_data_o,
    output logic         lane_clk_o
);
    pixel_t                 pix;
    slot_word_t [LANES-1:0] words;
    logic [SLOT_W-1:0]      slot;
    logic                   load;

    assign pix = {pix_r, pix_g, pix_b, pix_hs, pix_vs, pix_de};

    pix7_lane_mapper u_map (
        .pix_i   (pix),
        .sel_i   (map_e'(map_sel)),
        .words_o (words)
    );

    pix7_slot_seq u_seq (
        .clk        (clk_fast),
        .rst        (rst),
        .slot_o     (slot),
        .load_o     (load),
        .clk_lane_o (lane_clk_o)
    );

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            pix7_lane_shift u_shift (
                .clk      (clk_fast),
                .rst      (rst),
                .load_i   (load),
                .mirror_i (mirror),
                .word_i   (words[ln]),
                .bit_o    (lane_data_o[ln])
            );
        end
    endgenerate

    AST_RESET_LOW: assert property (@(posedge clk_fast)
        rst |=> (lane_data_o == '0 && !lane_clk_o));                         // R10
    AST_CTL3_ZERO: assert property (@(posedge clk_fast) disable iff (rst)
        $past(load && !mirror) |-> (lane_data_o[3] == 1'b0));                // R7
    AST_LOAD_SLOT0: assert property (@(posedge clk_fast) disable iff (rst)
        load |-> (slot == '0));                                              // R1
endmodule

// File: tb/pix7_serializer_bench.sv
`timescale 1ns/1ps
module pix7_serializer_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] pix_r, pix_g, pix_b;
    logic       pix_hs, pix_vs, pix_de;
    logic [1:0] map_sel;
    logic       mirror;
    logic [3:0] lane_data_o;
    logic       lane_clk_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [4:0] q_val[$];
    string      q_tag[$];

    always #10 clk = ~clk;

    pix7_serializer u_pix7_serializer (
        .clk_fast    (clk),
        .rst         (rst),
        .pix_r       (pix_r),
        .pix_g       (pix_g),
        .pix_b       (pix_b),
        .pix_hs      (pix_hs),
        .pix_vs      (pix_vs),
        .pix_de      (pix_de),
        .map_sel     (map_sel),
        .mirror      (mirror),
        .lane_data_o (lane_data_o),
        .lane_clk_o  (lane_clk_o)
    );

    // expected slot word of one lane, bit k = slot k
    function automatic logic [6:0] ref_lane(input logic [1:0] m, input int ln,
                                            input logic [7:0] r, input logic [7:0] g,
                                            input logic [7:0] b, input logic hs,
                                            input logic vs, input logic de);
        logic a24;
        logic b24;
        logic [6:0] s;
        a24 = (m == 2'd1);
        b24 = (m == 2'd2);
        case (ln)
            0: s = a24 ? {r[2], r[3], r[4], r[5], r[6], r[7], g[2]}
                       : {r[0], r[1], r[2], r[3], r[4], r[5], g[0]};
            1: s = a24 ? {g[3], g[4], g[5], g[6], g[7], b[2], b[3]}
                       : {g[1], g[2], g[3], g[4], g[5], b[0], b[1]};
            2: s = a24 ? {b[4], b[5], b[6], b[7], hs, vs, de}
                       : {b[2], b[3], b[4], b[5], hs, vs, de};
            default: s = a24 ? {r[0], r[1], g[0], g[1], b[0], b[1], 1'b0}
                       : (b24 ? {r[6], r[7], g[6], g[7], b[6], b[7], 1'b0} : 7'b0);
        endcase
        return s;
    endfunction

    // driver: called at a falling edge just before a slot-0 edge
    task automatic send(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                        input logic hs, input logic vs, input logic de,
                        input logic [1:0] m, input logic mir, input string tag,
                        input bit disturb);
        logic [6:0] w [4];
        pix_r = r; pix_g = g; pix_b = b;
        pix_hs = hs; pix_vs = vs; pix_de = de;
        map_sel = m; mirror = mir;
        for (int ln = 0; ln < 4; ln++) w[ln] = ref_lane(m, ln, r, g, b, hs, vs, de);
        for (int k = 0; k < 7; k++) begin
            int sl;
            logic ck;
            sl = mir ? 6 - k : k;
            ck = (k <= 1) || (k >= 5);
            q_val.push_back({ck, w[3][sl], w[2][sl], w[1][sl], w[0][sl]});
            q_tag.push_back(tag);
        end
        if (disturb) begin
            repeat (3) @(negedge clk);
            pix_r = ~r; pix_g = ~g; pix_b = ~b;
            pix_hs = ~hs; pix_vs = ~vs; pix_de = ~de;
            map_sel = m + 2'd1; mirror = ~mir;
            repeat (4) @(negedge clk);
        end else begin
            repeat (7) @(negedge clk);
        end
    endtask

    // reset while at a falling edge; checks outputs low (R10)
    task automatic do_reset();
        q_val.delete();
        q_tag.delete();
        rst = 1'b1;
        @(negedge clk);
        n_cmp++;
        if (lane_data_o !== 4'b0 || lane_clk_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: got lanes %b clk %b expected lanes 0000 clk 0",
                     lane_data_o, lane_clk_o);
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    // monitor: compares after every rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_val.size() > 0) begin
                logic [4:0] exp_v;
                string      tg;
                exp_v = q_val.pop_front();
                tg    = q_tag.pop_front();
                n_cmp++;
                if ({lane_clk_o, lane_data_o} !== exp_v) begin
                    n_bad++;
                    $display("FAIL %s: got clk/lanes %b expected %b", tg,
                             {lane_clk_o, lane_data_o}, exp_v);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        pix_r = 8'h00; pix_g = 8'h00; pix_b = 8'h00;
        pix_hs = 1'b0; pix_vs = 1'b0; pix_de = 1'b0;
        map_sel = 2'd0; mirror = 1'b0;
        repeat (2) @(negedge clk);
        do_reset();   // R10 reset state

        // R3 R2 R1: 18-bit layout
        send(8'h2D, 8'h96, 8'h5B, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, "R3", 1'b0);
        // R3: bits 7:6 ignored, same low bits
        send(8'hED, 8'h56, 8'h9B, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, "R3", 1'b0);
        // R7: control slots
        send(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, "R7", 1'b0);
        send(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, "R7", 1'b0);
        send(8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, "R7", 1'b0);
        // R4: first 24-bit layout
        send(8'hA5, 8'h3C, 8'hC3, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, "R4", 1'b0);
        send(8'h1E, 8'hE1, 8'h78, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, "R4", 1'b0);
        // R5: second 24-bit layout
        send(8'hA5, 8'h3C, 8'hC3, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0, "R5", 1'b0);
        send(8'h4E, 8'hB1, 8'h87, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, "R5", 1'b0);
        // R6: reserved code behaves as 18-bit
        send(8'hC9, 8'h72, 8'hB4, 1'b0, 1'b1, 1'b1, 2'd3, 1'b0, "R6", 1'b0);
        // R8: mirrored periods in each layout
        send(8'h2D, 8'h96, 8'h5B, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, "R8", 1'b0);
        send(8'hA5, 8'h3C, 8'hC3, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, "R8", 1'b0);
        send(8'h4E, 8'hB1, 8'h87, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, "R8", 1'b0);
        // R9: inputs disturbed mid-period
        send(8'h69, 8'hD2, 8'h1B, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, "R9", 1'b1);
        send(8'h35, 8'hCA, 8'h0F, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, "R9", 1'b1);
        // R10: reset in the middle of a period, then restart at slot 0
        pix_r = 8'hFF; pix_g = 8'hFF; pix_b = 8'hFF; map_sel = 2'd1;
        repeat (3) @(negedge clk);
        do_reset();
        send(8'h5A, 8'hA5, 8'h96, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, "R10", 1'b0);
        send(8'h81, 8'h42, 8'h24, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, "R10", 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule